// File: doc/BRIEF.md
# Sleep Button Debounce and Override

This block conditions an active-low sleep-button input that arrives from an always-on power-management domain. The raw pin first crosses into the local clock through a two-stage synchronizer. A filter then samples it once per millisecond tick and passes a level change only when that change has been seen on a fixed number of consecutive ticks. The clean press sets a sticky sleep-button status bit. While the system sits in any state other than fully on, that bit raises a wake request that the power sequencer can act on.

A separate hold timer watches the debounced press. When the press is held long enough and the system is not in soft-off, the timer produces an override event. The event sets a sticky override status bit and forces the active-low power-on request output to its inactive (high) level. The output stays forced until the sequencer asserts a release strobe. A pin-function select can hand the pin to a general-purpose I/O path, and while it does so the button function is off. Both status bits are cleared by write-one-to-clear strobes.

Top module: `sleep_button_ctrl`

## Requirements
- R1: After reset `btn_pressed`, `sleep_sts`, `ovr_sts` and `wake_req` are 0. `pwr_on_req_n` equals `seq_pwr_on_n`.
- R2: A low level on `btn_pin_n` that lasts fewer than DEB_TICKS ticks of `tick_ms` (one-cycle pulses) leaves `btn_pressed` at 0 and does not set `sleep_sts`.
- R3: `btn_pressed` changes only on a `tick_ms` cycle, and only after DEB_TICKS consecutive ticks whose synchronized sample differs from the current level. A press takes exactly DEB_TICKS ticks to appear and a release takes exactly DEB_TICKS ticks to clear. The rising edge of `btn_pressed` sets `sleep_sts` in the same cycle.
- R4: `sleep_sts` and `ovr_sts` hold once set and are cleared by a one-cycle pulse on `sleep_clr` or `ovr_clr` respectively. A set in the same cycle as a clear leaves the bit at 1.
- R5: `wake_req` is 1 exactly when `sleep_sts` is 1 and `pwr_state` is not fully on. Fully on is encoded as 3'd0.
- R6: While `pwr_state` is not soft-off, the HOLD_TICKS-th tick after `btn_pressed` rises, with no release in between, sets `ovr_sts` and drives `pwr_on_req_n` to 1. Soft-off is encoded as 3'd5. A press produces only one override, however long it is held.
- R7: Any tick or cycle with `pwr_state` equal to soft-off (3'd5) restarts the hold count. No override is generated while that state lasts.
- R8: After an override, `pwr_on_req_n` stays 1 until a pulse on `ovr_release`. Otherwise `pwr_on_req_n` follows `seq_pwr_on_n`.
- R9: While `pin_is_gpio` is 1, `btn_pressed` reads 0 from the next cycle onward and pin activity sets neither status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| btn_pin_n | input | 1 | Raw sleep-button pin, low when pressed |
| pin_is_gpio | input | 1 | 1 hands the pin to the GPIO path and disables the button |
| pwr_state | input | 3 | Current power state; 0 fully on, 5 soft-off |
| sleep_clr | input | 1 | Write-one-to-clear strobe for `sleep_sts` |
| ovr_clr | input | 1 | Write-one-to-clear strobe for `ovr_sts` |
| ovr_release | input | 1 | Ends the forced-inactive power-on request |
| seq_pwr_on_n | input | 1 | Power-on request from the sequencer, active low |
| btn_pressed | output | 1 | Debounced press level, 1 when pressed |
| sleep_sts | output | 1 | Sticky sleep-button status |
| ovr_sts | output | 1 | Sticky override status |
| wake_req | output | 1 | Wake request toward the sequencer |
| pwr_on_req_n | output | 1 | Power-on request output, active low |

## Verification
Press lengths are swept from one tick up to two ticks past the filter length. Each length shows whether the filter passes a press at exactly DEB_TICKS ticks and not one tick sooner, and the release is timed with the same tick count. The hold timer is driven through an uninterrupted press, a press made entirely in soft-off, and a press broken by a single soft-off tick. Together these separate a counter that fires at the wrong count from one that fails to restart. Strobe collisions with a status set, repeated holds after an override, and GPIO handover both before and during a press cover the sticky, once-only and disable paths.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned PS_W          = 3;
  localparam logic [PS_W-1:0] PS_FULLON  = 3'd0;
  localparam logic [PS_W-1:0] PS_SOFTOFF = 3'd5;
endpackage

// File: rtl/sbd_sync.sv
module sbd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sbd_debounce.sv
module sbd_debounce #(
  parameter int unsigned DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bypass,
  input  logic sample,
  output logic level,
  output logic rise
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (bypass) begin
      lvl_d = 1'b0;
      cnt_d = '0;
    end else if (tick) begin
      if (sample == lvl_q) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        lvl_d = sample;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level = lvl_q;
  assign rise  = lvl_d & ~lvl_q;
endmodule

// File: rtl/sbd_hold_timer.sv
module sbd_hold_timer #(
  parameter int unsigned HOLD_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pressed,
  input  logic inhibit,
  output logic fire
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    fire_d = 1'b0;
    if (!pressed || inhibit) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == LAST) begin
        fire_d = 1'b1;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign fire = fire_d;
endmodule

// File: rtl/sbd_sticky.sv
module sbd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_q, q_d;

  always_comb begin
    q_d = (q_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/sleep_button_ctrl.sv
module sleep_button_ctrl
  import sbd_pkg::*;
#(
  parameter int unsigned DEB_TICKS  = 16,
  parameter int unsigned HOLD_TICKS = 4000,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_ms,
  input  logic            btn_pin_n,
  input  logic            pin_is_gpio,
  input  logic [PS_W-1:0] pwr_state,
  input  logic            sleep_clr,
  input  logic            ovr_clr,
  input  logic            ovr_release,
  input  logic            seq_pwr_on_n,
  output logic            btn_pressed,
  output logic            sleep_sts,
  output logic            ovr_sts,
  output logic            wake_req,
  output logic            pwr_on_req_n
);
  logic pin_sync_n;
  logic press_rise;
  logic hold_fire;
  logic in_softoff;
  logic force_q, force_d;

  sbd_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_pin_n),
    .q     (pin_sync_n)
  );

  sbd_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .bypass (pin_is_gpio),
    .sample (~pin_sync_n),
    .level  (btn_pressed),
    .rise   (press_rise)
  );

  assign in_softoff = (pwr_state == PS_SOFTOFF);

  sbd_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_ms),
    .pressed (btn_pressed),
    .inhibit (in_softoff | pin_is_gpio),
    .fire    (hold_fire)
  );

  sbd_sticky u_sleep_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (press_rise),
    .clr   (sleep_clr),
    .q     (sleep_sts)
  );

  sbd_sticky u_ovr_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hold_fire),
    .clr   (ovr_clr),
    .q     (ovr_sts)
  );

  always_comb begin
    force_d = force_q;
    if (hold_fire)        force_d = 1'b1;
    else if (ovr_release) force_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= force_d;
  end

  assign pwr_on_req_n = force_q | seq_pwr_on_n;
  assign wake_req     = sleep_sts & (pwr_state != PS_FULLON);
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker
  import sbd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tick_ms,
  input logic            btn_pin_n,
  input logic            pin_is_gpio,
  input logic [PS_W-1:0] pwr_state,
  input logic            sleep_clr,
  input logic            ovr_clr,
  input logic            ovr_release,
  input logic            seq_pwr_on_n,
  input logic            btn_pressed,
  input logic            sleep_sts,
  input logic            ovr_sts,
  input logic            wake_req,
  input logic            pwr_on_req_n
);
  p_level_moves_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_pressed) |-> ($past(tick_ms) || $past(pin_is_gpio)));

  p_sleep_set_with_press_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_sts) |-> btn_pressed);

  p_sleep_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_sts && !sleep_clr) |=> sleep_sts);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sts && !ovr_clr) |=> ovr_sts);

  p_ovr_forces_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_sts) |-> pwr_on_req_n);

  p_no_ovr_in_softoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SOFTOFF) |=> !$rose(ovr_sts));

  p_force_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on_req_n && !seq_pwr_on_n && !ovr_release) |=> pwr_on_req_n || !$stable(seq_pwr_on_n));

  p_gpio_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_is_gpio |=> !btn_pressed);

  p_wake_needs_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleep_sts);
endmodule

bind sleep_button_ctrl sbd_checker u_chk (.*);

// File: tb/sleep_button_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_button_ctrl_tb;
  localparam int DEB  = 4;
  localparam int HOLD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic       btn_pin_n;
  logic       pin_is_gpio;
  logic [2:0] pwr_state;
  logic       sleep_clr;
  logic       ovr_clr;
  logic       ovr_release;
  logic       seq_pwr_on_n;
  logic       btn_pressed;
  logic       sleep_sts;
  logic       ovr_sts;
  logic       wake_req;
  logic       pwr_on_req_n;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sleep_button_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_ms      (tick_ms),
    .btn_pin_n    (btn_pin_n),
    .pin_is_gpio  (pin_is_gpio),
    .pwr_state    (pwr_state),
    .sleep_clr    (sleep_clr),
    .ovr_clr      (ovr_clr),
    .ovr_release  (ovr_release),
    .seq_pwr_on_n (seq_pwr_on_n),
    .btn_pressed  (btn_pressed),
    .sleep_sts    (sleep_sts),
    .ovr_sts      (ovr_sts),
    .wake_req     (wake_req),
    .pwr_on_req_n (pwr_on_req_n)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) btn_pin_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_sleep();
    @(negedge clk) sleep_clr = 1'b1;
    @(negedge clk) sleep_clr = 1'b0;
  endtask

  task automatic clr_ovr();
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
  endtask

  task automatic release_force();
    @(negedge clk) ovr_release = 1'b1;
    @(negedge clk) ovr_release = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; btn_pin_n = 1'b1; pin_is_gpio = 1'b0;
    pwr_state = 3'd3; sleep_clr = 1'b0; ovr_clr = 1'b0; ovr_release = 1'b0;
    seq_pwr_on_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(btn_pressed, 1'b0, "R1 btn_pressed");
    chk(sleep_sts, 1'b0, "R1 sleep_sts");
    chk(ovr_sts, 1'b0, "R1 ovr_sts");
    chk(wake_req, 1'b0, "R1 wake_req");
    chk(pwr_on_req_n, 1'b0, "R1 pwr_on_req_n follows seq");

    // R2/R3/R5 sweep of press length
    for (int len = 1; len <= DEB + 2; len++) begin
      set_pin(1'b0);
      ticks(len);
      chk(btn_pressed, logic'(len >= DEB), $sformatf("R2 R3 pressed after %0d ticks", len));
      chk(sleep_sts, logic'(len >= DEB), $sformatf("R3 sleep_sts after %0d ticks", len));
      chk(wake_req, logic'(len >= DEB), $sformatf("R5 wake_req in sleep len %0d", len));
      set_pin(1'b1);
      ticks(DEB - 1);
      chk(btn_pressed, logic'(len >= DEB), $sformatf("R3 release not yet len %0d", len));
      ticks(1);
      chk(btn_pressed, 1'b0, $sformatf("R3 release done len %0d", len));
      chk(sleep_sts, logic'(len >= DEB), $sformatf("R4 sleep_sts sticky len %0d", len));
      clr_sleep();
      chk(sleep_sts, 1'b0, $sformatf("R4 sleep_sts cleared len %0d", len));
    end

    // R5 no wake when fully on
    set_pin(1'b0); ticks(DEB); set_pin(1'b1); ticks(DEB);
    @(negedge clk) pwr_state = 3'd0;
    @(negedge clk);
    chk(wake_req, 1'b0, "R5 wake_req in fully on");
    pwr_state = 3'd3;
    @(negedge clk);
    chk(wake_req, 1'b1, "R5 wake_req back in sleep");
    clr_sleep();

    // R4 set wins over clear in the same cycle
    set_pin(1'b0);
    ticks(DEB - 1);
    @(negedge clk) begin tick_ms = 1'b1; sleep_clr = 1'b1; end
    @(negedge clk) begin tick_ms = 1'b0; sleep_clr = 1'b0; end
    chk(sleep_sts, 1'b1, "R4 set beats clear");
    set_pin(1'b1); ticks(DEB); clr_sleep();

    // R6/R8 override on a continuous hold
    set_pin(1'b0);
    ticks(DEB);
    ticks(HOLD - 1);
    chk(ovr_sts, 1'b0, "R6 no override one tick early");
    chk(pwr_on_req_n, 1'b0, "R6 request not forced yet");
    ticks(1);
    chk(ovr_sts, 1'b1, "R6 override set");
    chk(pwr_on_req_n, 1'b1, "R6 request forced high");
    clr_ovr();
    chk(ovr_sts, 1'b0, "R4 ovr_sts cleared");
    ticks(HOLD + 2);
    chk(ovr_sts, 1'b0, "R6 single override per press");
    chk(pwr_on_req_n, 1'b1, "R8 force persists");
    set_pin(1'b1); ticks(DEB);
    chk(pwr_on_req_n, 1'b1, "R8 force persists after release of button");
    release_force();
    chk(pwr_on_req_n, 1'b0, "R8 force ended by release");
    @(negedge clk) seq_pwr_on_n = 1'b1;
    @(negedge clk);
    chk(pwr_on_req_n, 1'b1, "R8 follows sequencer high");
    seq_pwr_on_n = 1'b0;
    clr_sleep();

    // R7 soft-off for the whole press
    @(negedge clk) pwr_state = 3'd5;
    set_pin(1'b0);
    ticks(DEB + HOLD + 3);
    chk(ovr_sts, 1'b0, "R7 no override in soft-off");
    chk(pwr_on_req_n, 1'b0, "R7 request untouched in soft-off");
    set_pin(1'b1); ticks(DEB); clr_sleep();

    // R7 one soft-off tick restarts the count
    @(negedge clk) pwr_state = 3'd3;
    set_pin(1'b0);
    ticks(DEB);
    ticks(HOLD - 2);
    @(negedge clk) pwr_state = 3'd5;
    ticks(1);
    @(negedge clk) pwr_state = 3'd3;
    ticks(HOLD - 1);
    chk(ovr_sts, 1'b0, "R7 count restarted by soft-off");
    ticks(1);
    chk(ovr_sts, 1'b1, "R7 override after full count");
    set_pin(1'b1); ticks(DEB); clr_ovr(); clr_sleep(); release_force();

    // R9 GPIO select
    @(negedge clk) pin_is_gpio = 1'b1;
    set_pin(1'b0);
    ticks(DEB + 2);
    chk(btn_pressed, 1'b0, "R9 no press while gpio");
    chk(sleep_sts, 1'b0, "R9 no status while gpio");
    @(negedge clk) pin_is_gpio = 1'b0;
    ticks(DEB);
    chk(btn_pressed, 1'b1, "R9 press seen after gpio off");
    clr_sleep();
    @(negedge clk) pin_is_gpio = 1'b1;
    @(negedge clk);
    chk(btn_pressed, 1'b0, "R9 level cleared one cycle after select");
    ticks(HOLD + 2);
    chk(ovr_sts, 1'b0, "R9 no override while gpio");
    chk(sleep_sts, 1'b0, "R9 no status during gpio handover");
    set_pin(1'b1);
    @(negedge clk) pin_is_gpio = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule